// File: doc/BRIEF.md
# Memory Ordering Issue Queue

This block keeps dispatched memory operations in program order and picks, once per cycle, one held operation that may issue under a weak consistency model. Each held entry is a load, a store, a load barrier, a store barrier or a full barrier. The kind comes from three dispatch flags: reads memory, writes memory, and has side effects. Every accepted operation receives a small tag. The issue port reports the tag, the kind and the address. A completion pulse that carries the tag removes the entry. The remaining entries then close up and keep their age order.

Ordering is always judged against older entries that are still held, meaning they have not yet completed. A younger load may overtake older loads freely while nothing that orders it lies between them. It may overtake an older store only when the two addresses differ. A configuration input can declare that loads never alias stores. Stores never overtake older loads or stores. A barrier issues only as the oldest held entry, and it holds back the younger operations it orders until it completes.

Top module: `mq_order_iq`

## Requirements
- R1: Each accepted operation holds exactly one entry until its completion. `disp_ready` is low while DEPTH entries are held, an operation is accepted only on a cycle with `disp_valid` and `disp_ready` both high, and `disp_ready` rises again the cycle after a completion frees an entry.
- R2: Kind decoding, reported on `iss_kind`: side+read+write gives full barrier (4); side+read gives load barrier (2); side+write gives store barrier (3); write without side effect gives store (1); every other combination gives load (0).
- R3: An accepted operation gets the lowest tag in 0..DEPTH-1 not held by another entry. A completion with `cmp_tag` equal to a held entry's tag removes that entry and frees the tag.
- R4: At most one grant per cycle. The oldest eligible entry that has not been granted yet wins, and `iss_valid`, `iss_tag`, `iss_kind` and `iss_addr` show it on the cycle after the decision. An entry is granted only once.
- R5: A load may overtake an older held load only when no store or barrier is held between them in program order.
- R6: A store is never granted while an older store is held.
- R7: A store is never granted while an older load is held.
- R8: With `cfg_no_alias` low, a load is not granted while an older held store has an equal address. With `cfg_no_alias` high, this check is skipped.
- R9: A held load or full barrier blocks younger loads. A held store or full barrier blocks younger stores. A load barrier does not block stores, and a store barrier does not block loads.
- R10: A barrier is granted only while it is the oldest held entry.
- R11: After reset the queue is empty, `disp_ready` is high and `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_no_alias | input | 1 | Loads are assumed never to alias stores |
| disp_valid | input | 1 | Dispatch request |
| disp_rd | input | 1 | Operation reads memory |
| disp_wr | input | 1 | Operation writes memory |
| disp_side | input | 1 | Operation has side effects |
| disp_addr | input | AW | Address tag of the operation |
| disp_ready | output | 1 | A free entry exists |
| iss_valid | output | 1 | Grant made this cycle |
| iss_tag | output | $clog2(DEPTH) | Tag of the granted entry |
| iss_kind | output | 3 | Kind of the granted entry |
| iss_addr | output | AW | Address of the granted entry |
| cmp_valid | input | 1 | Completion pulse |
| cmp_tag | input | $clog2(DEPTH) | Tag of the completing entry |

## Verification
The bench builds the queue with DEPTH=4 and AW=8. With four entries a full queue is reached in four dispatches, so the refused dispatch and the reuse of the lowest freed tag can both be seen at the ports. Four entries also give room for one operation before and two after each barrier. That lets every pairwise ordering case, including the aliasing store under both settings of the no-alias input, play out in a few cycles with completions under the bench's control.

// File: rtl/mq_pkg.sv
package mq_pkg;
  typedef enum logic [2:0] {
    K_LOAD  = 3'd0,
    K_STORE = 3'd1,
    K_LBAR  = 3'd2,
    K_SBAR  = 3'd3,
    K_FBAR  = 3'd4
  } kind_e;
endpackage

// File: rtl/mq_kind_dec.sv
module mq_kind_dec
  import mq_pkg::*;
(
  input  logic  rd,
  input  logic  wr,
  input  logic  side,
  output kind_e kind
);
  always_comb begin
    if (side && rd && wr)  kind = K_FBAR;
    else if (side && rd)   kind = K_LBAR;
    else if (side && wr)   kind = K_SBAR;
    else if (wr)           kind = K_STORE;
    else                   kind = K_LOAD;
  end
endmodule

// File: rtl/mq_pick.sv
module mq_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        found = 1'b1;
        idx   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/mq_elig.sv
module mq_elig
  import mq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16
) (
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] granted,
  input  kind_e            kind [DEPTH],
  input  logic [AW-1:0]    addr [DEPTH],
  input  logic             no_alias,
  output logic [DEPTH-1:0] elig
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_comb begin
      logic ld_before, order_gap, old_ld, old_st, lb_held, sb_held, same_addr, ok;
      ld_before = 1'b0;
      order_gap = 1'b0;
      old_ld    = 1'b0;
      old_st    = 1'b0;
      lb_held   = 1'b0;
      sb_held   = 1'b0;
      same_addr = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (vld[j]) begin
          if (kind[j] != K_LOAD && ld_before) order_gap = 1'b1;
          if (kind[j] == K_LOAD) begin
            ld_before = 1'b1;
            old_ld    = 1'b1;
          end
          if (kind[j] == K_STORE) begin
            old_st = 1'b1;
            if (addr[j] == addr[i]) same_addr = 1'b1;
          end
          if (kind[j] == K_LBAR || kind[j] == K_FBAR) lb_held = 1'b1;
          if (kind[j] == K_SBAR || kind[j] == K_FBAR) sb_held = 1'b1;
        end
      end
      case (kind[i])
        K_LOAD:  ok = !lb_held && !order_gap && (no_alias || !same_addr);
        K_STORE: ok = !old_ld && !old_st && !sb_held;
        default: ok = (i == 0);
      endcase
      elig[i] = vld[i] && !granted[i] && ok;
    end
  end
endmodule

// File: rtl/mq_order_iq.sv
module mq_order_iq
  import mq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_no_alias,
  input  logic          disp_valid,
  input  logic          disp_rd,
  input  logic          disp_wr,
  input  logic          disp_side,
  input  logic [AW-1:0] disp_addr,
  output logic          disp_ready,
  output logic          iss_valid,
  output logic [TW-1:0] iss_tag,
  output logic [2:0]    iss_kind,
  output logic [AW-1:0] iss_addr,
  input  logic          cmp_valid,
  input  logic [TW-1:0] cmp_tag
);
  logic [DEPTH-1:0] q_vld, q_gnt, n_vld, n_gnt, mk_gnt, tag_used, n_used, elig;
  kind_e            q_kind [DEPTH];
  kind_e            n_kind [DEPTH];
  logic [AW-1:0]    q_addr [DEPTH];
  logic [AW-1:0]    n_addr [DEPTH];
  logic [TW-1:0]    q_tag  [DEPTH];
  logic [TW-1:0]    n_tag  [DEPTH];
  logic [CW-1:0]    count, n_count, wr_pos;
  kind_e            new_kind;
  logic             gnt, free_ok, fire, rm_hit;
  logic [TW-1:0]    gidx, free_tag, rm_pos;

  mq_kind_dec u_dec (.rd(disp_rd), .wr(disp_wr), .side(disp_side), .kind(new_kind));

  mq_elig #(.DEPTH(DEPTH), .AW(AW)) u_elig (
    .vld(q_vld), .granted(q_gnt), .kind(q_kind), .addr(q_addr),
    .no_alias(cfg_no_alias), .elig(elig)
  );

  mq_pick #(.N(DEPTH)) u_age_pick  (.req(elig),      .found(gnt),     .idx(gidx));
  mq_pick #(.N(DEPTH)) u_free_pick (.req(~tag_used), .found(free_ok), .idx(free_tag));

  assign fire = disp_valid && disp_ready && free_ok;

  always_comb begin
    rm_hit = 1'b0;
    rm_pos = '0;
    for (int p = 0; p < DEPTH; p++) begin
      if (cmp_valid && q_vld[p] && q_tag[p] == cmp_tag) begin
        rm_hit = 1'b1;
        rm_pos = TW'(p);
      end
    end
  end

  always_comb begin
    mk_gnt = q_gnt;
    if (gnt) mk_gnt[gidx] = 1'b1;
    wr_pos = count - CW'(rm_hit);
    for (int p = 0; p < DEPTH; p++) begin
      if (rm_hit && p >= int'(rm_pos)) begin
        if (p < DEPTH - 1) begin
          n_vld[p]  = q_vld[p+1];
          n_gnt[p]  = mk_gnt[p+1];
          n_kind[p] = q_kind[p+1];
          n_addr[p] = q_addr[p+1];
          n_tag[p]  = q_tag[p+1];
        end else begin
          n_vld[p]  = 1'b0;
          n_gnt[p]  = 1'b0;
          n_kind[p] = K_LOAD;
          n_addr[p] = '0;
          n_tag[p]  = '0;
        end
      end else begin
        n_vld[p]  = q_vld[p];
        n_gnt[p]  = mk_gnt[p];
        n_kind[p] = q_kind[p];
        n_addr[p] = q_addr[p];
        n_tag[p]  = q_tag[p];
      end
      if (fire && CW'(p) == wr_pos) begin
        n_vld[p]  = 1'b1;
        n_gnt[p]  = 1'b0;
        n_kind[p] = new_kind;
        n_addr[p] = disp_addr;
        n_tag[p]  = free_tag;
      end
    end
    n_used = tag_used;
    if (rm_hit) n_used[cmp_tag] = 1'b0;
    if (fire)   n_used[free_tag] = 1'b1;
    n_count = count + CW'(fire) - CW'(rm_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld      <= '0;
      q_gnt      <= '0;
      tag_used   <= '0;
      count      <= '0;
      disp_ready <= 1'b1;
      iss_valid  <= 1'b0;
      iss_tag    <= '0;
      iss_kind   <= '0;
      iss_addr   <= '0;
      for (int p = 0; p < DEPTH; p++) begin
        q_kind[p] <= K_LOAD;
        q_addr[p] <= '0;
        q_tag[p]  <= '0;
      end
    end else begin
      q_vld      <= n_vld;
      q_gnt      <= n_gnt;
      tag_used   <= n_used;
      count      <= n_count;
      disp_ready <= (n_count != CW'(DEPTH));
      iss_valid  <= gnt;
      iss_tag    <= q_tag[gidx];
      iss_kind   <= q_kind[gidx];
      iss_addr   <= q_addr[gidx];
      for (int p = 0; p < DEPTH; p++) begin
        q_kind[p] <= n_kind[p];
        q_addr[p] <= n_addr[p];
        q_tag[p]  <= n_tag[p];
      end
    end
  end
endmodule

// File: rtl/mq_order_iq_chk.sv
module mq_order_iq_chk #(
  parameter int DEPTH = 8,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          disp_valid,
  input logic          disp_ready,
  input logic          cmp_valid,
  input logic          iss_valid,
  input logic [TW-1:0] iss_tag,
  input logic [2:0]    iss_kind,
  input logic [TW-1:0] head_tag
);
  logic [CW-1:0] occ;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else occ <= occ + CW'(disp_valid && disp_ready) - CW'(cmp_valid && occ != '0);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH)); // R1
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(DEPTH)) |-> !disp_ready); // R1
  AST_BAR_AT_HEAD: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_kind >= 3'd2) |-> (iss_tag == $past(head_tag))); // R10
  AST_NO_REGRANT: assert property (@(posedge clk) disable iff (rst)
    iss_valid |=> !(iss_valid && iss_tag == $past(iss_tag))); // R4
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> ($past(occ) != '0)); // R4
endmodule

bind mq_order_iq mq_order_iq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .cmp_valid(cmp_valid), .iss_valid(iss_valid), .iss_tag(iss_tag),
  .iss_kind(iss_kind), .head_tag(q_tag[0])
);

// File: tb/sim_mq_order_iq.sv
module sim_mq_order_iq;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int AW    = 8;
  localparam int TW    = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_no_alias = 1'b0;
  logic          disp_valid = 1'b0, disp_rd = 1'b0, disp_wr = 1'b0, disp_side = 1'b0;
  logic [AW-1:0] disp_addr = '0;
  logic          disp_ready, iss_valid;
  logic [TW-1:0] iss_tag;
  logic [2:0]    iss_kind;
  logic [AW-1:0] iss_addr;
  logic          cmp_valid = 1'b0;
  logic [TW-1:0] cmp_tag = '0;

  int checks = 0, failures = 0;
  int gcnt = 0;
  int g_tag [64];
  int g_kind [64];
  int g_addr [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  mq_order_iq #(.DEPTH(DEPTH), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .cfg_no_alias(cfg_no_alias),
    .disp_valid(disp_valid), .disp_rd(disp_rd), .disp_wr(disp_wr),
    .disp_side(disp_side), .disp_addr(disp_addr), .disp_ready(disp_ready),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_kind(iss_kind),
    .iss_addr(iss_addr), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag)
  );

  always @(posedge clk) begin
    if (!rst && iss_valid && gcnt < 64) begin
      g_tag[gcnt]  = int'(iss_tag);
      g_kind[gcnt] = int'(iss_kind);
      g_addr[gcnt] = int'(iss_addr);
      gcnt = gcnt + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    gcnt = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dsp(input logic rd, input logic wr, input logic se, input int a);
    disp_valid = 1'b1; disp_rd = rd; disp_wr = wr; disp_side = se; disp_addr = AW'(a);
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic cmp(input int t);
    cmp_valid = 1'b1; cmp_tag = TW'(t);
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 ready after reset", int'(disp_ready), 1);
    check("R11 no grant after reset", int'(iss_valid), 0);
  endtask

  task automatic t_alias();
    do_reset(); cfg_no_alias = 1'b0;
    dsp(0,1,0,5); dsp(1,0,0,5); dsp(1,0,0,9);
    idle(4);
    check("R8 aliasing load held, count", gcnt, 2);
    check("R8 store granted first", g_tag[0], 0);
    check("R5 load passes held older load", g_tag[1], 2);
    check("R4 grant carries address", g_addr[1], 9);
    cmp(0); idle(3);
    check("R8 aliasing load after store completes", gcnt, 3);
    check("R8 aliasing load tag", g_tag[2], 1);
  endtask

  task automatic t_noalias();
    do_reset(); cfg_no_alias = 1'b1;
    dsp(0,1,0,5); dsp(1,0,0,5); dsp(1,0,0,9);
    idle(4);
    check("R8 no-alias mode count", gcnt, 3);
    check("R8 no-alias mode order", g_tag[1], 1);
    check("R2 store kind code", g_kind[0], 1);
    cfg_no_alias = 1'b0;
  endtask

  task automatic t_store_order();
    do_reset();
    dsp(1,0,0,1); dsp(0,1,0,2); dsp(0,1,0,3);
    idle(4);
    check("R7 store waits for older load", gcnt, 1);
    cmp(0); idle(4);
    check("R6 second store waits for older store", gcnt, 2);
    check("R7 first store after load done", g_tag[1], 1);
    cmp(1); idle(3);
    check("R6 second store after first done", gcnt, 3);
    check("R6 second store tag", g_tag[2], 2);
  endtask

  task automatic t_rule_gap();
    do_reset();
    dsp(1,0,0,1); dsp(0,1,0,2); dsp(1,0,0,3);
    idle(4);
    check("R5 load behind store gap held", gcnt, 1);
    cmp(0); idle(4);
    check("R5 both granted after gap clears", gcnt, 3);
    check("R4 oldest first", g_tag[1], 1);
    check("R5 load after store", g_tag[2], 2);
  endtask

  task automatic t_lbar();
    do_reset();
    dsp(1,0,0,1); dsp(1,0,1,0); dsp(0,1,0,3); dsp(1,0,0,4);
    idle(4);
    check("R10 load barrier not granted behind load", gcnt, 1);
    cmp(0); idle(4);
    check("R9 store passes load barrier, count", gcnt, 3);
    check("R10 barrier granted at head", g_tag[1], 1);
    check("R2 load barrier kind code", g_kind[1], 2);
    check("R9 store passes load barrier", g_tag[2], 2);
    cmp(1); idle(3);
    check("R9 load released by barrier completion", gcnt, 4);
    check("R2 load kind code", g_kind[3], 0);
  endtask

  task automatic t_sbar();
    do_reset();
    dsp(0,1,0,1); dsp(0,1,1,0); dsp(1,0,0,2); dsp(0,1,0,3);
    idle(4);
    check("R9 load passes store barrier, count", gcnt, 2);
    check("R9 load passes store barrier", g_tag[1], 2);
    cmp(0); cmp(2); idle(4);
    check("R9 store held by store barrier", gcnt, 3);
    check("R2 store barrier kind code", g_kind[2], 3);
    cmp(1); idle(3);
    check("R9 store after barrier completes", gcnt, 4);
    check("R9 store tag", g_tag[3], 3);
  endtask

  task automatic t_fbar();
    do_reset();
    dsp(1,0,0,1); dsp(1,1,1,0); dsp(1,0,0,2); dsp(0,1,0,3);
    idle(4);
    check("R10 full barrier waits for head", gcnt, 1);
    cmp(0); idle(4);
    check("R9 full barrier blocks both", gcnt, 2);
    check("R2 full barrier kind code", g_kind[1], 4);
    cmp(1); idle(4);
    check("R7 store still behind load", gcnt, 3);
    check("R9 load after full barrier", g_tag[2], 2);
    cmp(2); idle(3);
    check("R7 store after load done", g_tag[3], 3);
  endtask

  task automatic t_full();
    do_reset();
    dsp(1,0,0,1); dsp(1,0,0,2); dsp(1,0,0,3); dsp(1,0,0,4);
    check("R1 ready low when full", int'(disp_ready), 0);
    dsp(1,0,0,7);
    idle(4);
    check("R1 refused dispatch not held", gcnt, 4);
    cmp(1);
    check("R1 ready after completion", int'(disp_ready), 1);
    dsp(1,0,0,8); idle(4);
    check("R3 lowest free tag reused", g_tag[4], 1);
    check("R3 new entry address", g_addr[4], 8);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL R4 watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_alias();
    t_noalias();
    t_store_order();
    t_rule_gap();
    t_lbar();
    t_sbar();
    t_fbar();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule